// File: doc/BRIEF.md
# Pending Miss Status Table

This block is a small register table that tracks coherence transactions still in flight for a private cache. There is one entry per hardware thread. A downstream processing stage writes the table through a single port. It can allocate an entry, rewrite an entry or retire an entry. At the same time, several request classes probe the table. Each probe gives a set index and gets back whether any live entry covers that set, which entry it is, and that entry's contents. The block also names a free slot, so the processing stage has a target for its next allocation. Block data is not kept here, because it lives in a separate store.

A build-time switch chooses how a write and a lookup in the same cycle interact. In bypass mode, lookups see the value being written. In ordered mode, lookups see only committed register contents, so a write shows up one cycle after it is issued.

Top module: `pmst_table`

## Requirements
- R1: On an asynchronous reset every entry goes to all zeros. After that, no lookup port hits, every lookup returns index 0 with an all-zero entry, `freeValid` is 1 and `freeIdx` is 0.
- R2: A write with `wrEn`=1 and `wrOp`=0 (allocate) stores `{1'b1, wrPayload}` into entry `wrIdx`. Entries are 17 bits with default parameters. The layout is valid[16], tag[15:12], set[11:9], thread[8:7], wakeup[6], state[5:4], evict[3], acks[2:0].
- R3: A write with `wrOp`=1 (update) overwrites the whole entry at `wrIdx` with `{1'b1, wrPayload}`.
- R4: A write with `wrOp`=2 (retire) clears only the valid bit of entry `wrIdx`. The other fields keep their values.
- R5: When `wrEn`=0, or when `wrOp`=3, no entry changes.
- R6: A lookup port hits an entry only when that entry is valid and its set field equals the port's queried set. The tag and all other fields play no part in the match.
- R7: The returned index is the lowest-numbered matching entry, in binary, and `lkEntry` is that entry. On a miss the index is 0 and `lkEntry` shows entry 0, including its valid bit.
- R8: Every lookup port (port p uses slice p of `lkSet`, `lkHit`, `lkIdx`, `lkEntry`) resolves its own query independently of the other ports.
- R9: `freeIdx` is the lowest-numbered entry whose committed valid bit is 0, and `freeValid` is 1 when such an entry exists. When every entry is valid, `freeValid` is 0 and `freeIdx` is 0.
- R10: With `WRITE_FIRST`=1, lookups in the cycle of a write already see the written or retired entry. With `WRITE_FIRST`=0, they see the old contents until the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| wrEn | input | 1 | Write command valid |
| wrOp | input | 2 | 0 allocate, 1 update, 2 retire, 3 no operation |
| wrIdx | input | IDX_W | Entry addressed by the write |
| wrPayload | input | PAY_W | Entry fields except valid |
| lkSet | input | NUM_PORTS*SET_W | Queried set index per lookup port |
| lkHit | output | NUM_PORTS | Hit per lookup port |
| lkIdx | output | NUM_PORTS*IDX_W | Lowest matching entry per port |
| lkEntry | output | NUM_PORTS*ENTRY_W | Contents of the returned entry per port |
| freeValid | output | 1 | A free entry exists |
| freeIdx | output | IDX_W | Lowest free entry |

## Verification
The assertions assume the writer never addresses an entry outside the table, so each write or retire lands on a real slot whose result is checked on the next edge. They also assume the lookup sets are stable around the clock edge, because hit consistency is sampled there. The bench always drives `wrIdx` below the entry count and changes queries and commands only just after the falling edge, so it stays within both assumptions. Both write orderings are instantiated side by side on the same stimulus, and every set value is swept on every port before and after each command.

// File: rtl/pmst_pkg.sv
package pmst_pkg;

  typedef enum logic [1:0] {
    OP_ALLOC   = 2'd0,
    OP_UPDATE  = 2'd1,
    OP_RETIRE  = 2'd2,
    OP_NONE    = 2'd3
  } pmst_op_e;

  // Strobes from control to the entry registers
  typedef struct packed {
    logic fill;   // write full entry, valid set
    logic clear;  // drop valid bit only
  } pmst_strobe_t;

endpackage

// File: rtl/pmst_ctrl.sv
module pmst_ctrl
  import pmst_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int IDX_W       = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wrEn,
  input  logic [1:0]             wrOp,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [NUM_ENTRIES-1:0] validVec,
  output pmst_strobe_t           strobe,
  output logic                   freeValid,
  output logic [IDX_W-1:0]       freeIdx
);

  logic idxInRange;
  pmst_op_e opCode;

  assign opCode     = pmst_op_e'(wrOp);
  assign idxInRange = {1'b0, wrIdx} < (IDX_W+1)'(NUM_ENTRIES);

  always_comb begin
    strobe.fill  = wrEn && idxInRange && (opCode == OP_ALLOC || opCode == OP_UPDATE);
    strobe.clear = wrEn && idxInRange && (opCode == OP_RETIRE);
  end

  // Lowest free slot, taken from committed state
  always_comb begin
    freeValid = 1'b0;
    freeIdx   = '0;
    for (int i = NUM_ENTRIES-1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeValid = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
  end

  // R9: reported slot is really free, and a full table reports none
  p_free_slot_r9: assert property (@(posedge clk) disable iff (rst)
    freeValid |-> !validVec[freeIdx]);
  p_full_table_r9: assert property (@(posedge clk) disable iff (rst)
    !freeValid |-> (&validVec));

endmodule

// File: rtl/pmst_datapath.sv
module pmst_datapath
  import pmst_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int NUM_PORTS   = 5,
  parameter int IDX_W       = 2,
  parameter int SET_W       = 3,
  parameter int PAY_W       = 16,
  parameter int SET_LSB     = 9,
  parameter bit WRITE_FIRST = 1'b0
) (
  input  logic                             clk,
  input  logic                             rst,
  input  pmst_strobe_t                     strobe,
  input  logic [IDX_W-1:0]                 wrIdx,
  input  logic [PAY_W-1:0]                 wrPayload,
  input  logic [NUM_PORTS*SET_W-1:0]       lkSet,
  output logic [NUM_ENTRIES-1:0]           validVec,
  output logic [NUM_PORTS-1:0]             lkHit,
  output logic [NUM_PORTS*IDX_W-1:0]       lkIdx,
  output logic [NUM_PORTS*(PAY_W+1)-1:0]   lkEntry
);

  localparam int ENTRY_W = PAY_W + 1;
  localparam int VLD     = ENTRY_W - 1;
  localparam int SET_MSB = SET_LSB + SET_W - 1;

  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] store;
  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] view;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic         selHere;
    logic [ENTRY_W-1:0] nextVal;

    assign selHere = (strobe.fill || strobe.clear) && (wrIdx == IDX_W'(e));
    assign nextVal = strobe.fill ? {1'b1, wrPayload} : {1'b0, store[e][PAY_W-1:0]};

    always_ff @(posedge clk or posedge rst) begin
      if (rst)          store[e] <= '0;
      else if (selHere) store[e] <= nextVal;
    end

    if (WRITE_FIRST) begin : g_bypass
      assign view[e] = selHere ? nextVal : store[e];
    end else begin : g_ordered
      assign view[e] = store[e];
    end

    assign validVec[e] = store[e][VLD];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [NUM_ENTRIES-1:0] matchVec;
    logic [IDX_W-1:0]       selIdx;
    logic [SET_W-1:0]       query;

    assign query = lkSet[p*SET_W +: SET_W];

    always_comb begin
      for (int i = 0; i < NUM_ENTRIES; i++)
        matchVec[i] = view[i][VLD] && (view[i][SET_MSB:SET_LSB] == query);
    end

    always_comb begin
      selIdx = '0;
      for (int i = NUM_ENTRIES-1; i >= 0; i--)
        if (matchVec[i]) selIdx = IDX_W'(i);
    end

    assign lkHit[p]                     = |matchVec;
    assign lkIdx[p*IDX_W +: IDX_W]       = selIdx;
    assign lkEntry[p*ENTRY_W +: ENTRY_W] = view[selIdx];

    // R6: a reported hit always carries a live entry of the queried set
    p_hit_match_r6: assert property (@(posedge clk) disable iff (rst)
      lkHit[p] |-> (lkEntry[p*ENTRY_W + VLD] &&
                    lkEntry[p*ENTRY_W + SET_LSB +: SET_W] == query));
  end

  // R2, R3: a fill commits the full entry at the addressed slot
  p_fill_commit_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.fill |=> store[$past(wrIdx)] == {1'b1, $past(wrPayload)});
  // R4: a retire leaves the addressed slot invalid
  p_retire_drop_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.clear |=> !validVec[$past(wrIdx)]);
  // R5: with no strobe the table holds still
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(strobe.fill || strobe.clear) |=> $stable(store));

endmodule

// File: rtl/pmst_table.sv
module pmst_table
  import pmst_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int NUM_PORTS   = 5,
  parameter int TAG_W       = 4,
  parameter int SET_W       = 3,
  parameter int THR_W       = 2,
  parameter int STATE_W     = 2,
  parameter int ACK_W       = 3,
  parameter bit WRITE_FIRST = 1'b0,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int SET_LSB    = THR_W + 1 + STATE_W + 1 + ACK_W,
  localparam int PAY_W      = TAG_W + SET_W + SET_LSB,
  localparam int ENTRY_W    = PAY_W + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wrEn,
  input  logic [1:0]                   wrOp,
  input  logic [IDX_W-1:0]             wrIdx,
  input  logic [PAY_W-1:0]             wrPayload,
  input  logic [NUM_PORTS*SET_W-1:0]   lkSet,
  output logic [NUM_PORTS-1:0]         lkHit,
  output logic [NUM_PORTS*IDX_W-1:0]   lkIdx,
  output logic [NUM_PORTS*ENTRY_W-1:0] lkEntry,
  output logic                         freeValid,
  output logic [IDX_W-1:0]             freeIdx
);

  pmst_strobe_t           strobe;
  logic [NUM_ENTRIES-1:0] validVec;

  pmst_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .wrOp     (wrOp),
    .wrIdx    (wrIdx),
    .validVec (validVec),
    .strobe   (strobe),
    .freeValid(freeValid),
    .freeIdx  (freeIdx)
  );

  pmst_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .NUM_PORTS  (NUM_PORTS),
    .IDX_W      (IDX_W),
    .SET_W      (SET_W),
    .PAY_W      (PAY_W),
    .SET_LSB    (SET_LSB),
    .WRITE_FIRST(WRITE_FIRST)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .wrPayload(wrPayload),
    .lkSet    (lkSet),
    .validVec (validVec),
    .lkHit    (lkHit),
    .lkIdx    (lkIdx),
    .lkEntry  (lkEntry)
  );

endmodule

// File: tb/pmst_table_bench.sv
`timescale 1ns/1ps
module pmst_table_bench;

  localparam int N       = 4;
  localparam int P       = 5;
  localparam int IDX_W   = 2;
  localparam int SET_W   = 3;
  localparam int PAY_W   = 16;
  localparam int ENTRY_W = 17;
  localparam int SETS    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [1:0] wrOp = 2'd0;
  logic [IDX_W-1:0] wrIdx = '0;
  logic [PAY_W-1:0] wrPayload = '0;
  logic [P*SET_W-1:0] lkSet = '0;

  logic [P-1:0]         rbHit, wfHit;
  logic [P*IDX_W-1:0]   rbIdx, wfIdx;
  logic [P*ENTRY_W-1:0] rbEntry, wfEntry;
  logic                 rbFreeV, wfFreeV;
  logic [IDX_W-1:0]     rbFree, wfFree;

  always #2 clk = ~clk;

  pmst_table #(.WRITE_FIRST(1'b0)) u_pmst_table (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrOp(wrOp), .wrIdx(wrIdx),
    .wrPayload(wrPayload), .lkSet(lkSet), .lkHit(rbHit), .lkIdx(rbIdx),
    .lkEntry(rbEntry), .freeValid(rbFreeV), .freeIdx(rbFree));

  pmst_table #(.WRITE_FIRST(1'b1)) u_pmst_table_wf (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrOp(wrOp), .wrIdx(wrIdx),
    .wrPayload(wrPayload), .lkSet(lkSet), .lkHit(wfHit), .lkIdx(wfIdx),
    .lkEntry(wfEntry), .freeValid(wfFreeV), .freeIdx(wfFree));

  logic [ENTRY_W-1:0] mStore [N];
  logic [ENTRY_W-1:0] mView  [N];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PAY_W-1:0] mk(input int tag, input int set, input int thr,
                                          input int wk, input int st, input int ev, input int ack);
    return {4'(tag), 3'(set), 2'(thr), 1'(wk), 2'(st), 1'(ev), 3'(ack)};
  endfunction

  // Expected lookup: useView picks the bypassed model
  task automatic expect_look(input bit useView, input int q, output logic hit,
                             output logic [IDX_W-1:0] idx, output logic [ENTRY_W-1:0] ent);
    hit = 1'b0; idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      logic [ENTRY_W-1:0] e;
      e = useView ? mView[i] : mStore[i];
      if (e[16] && int'(e[11:9]) == q) begin hit = 1'b1; idx = IDX_W'(i); end
    end
    ent = useView ? mView[idx] : mStore[idx];
  endtask

  task automatic sweep(input string req);
    logic eh; logic [IDX_W-1:0] ei; logic [ENTRY_W-1:0] ee;
    logic efv; logic [IDX_W-1:0] efi;
    efv = 1'b0; efi = '0;
    for (int i = N-1; i >= 0; i--)
      if (!mStore[i][16]) begin efv = 1'b1; efi = IDX_W'(i); end
    check({req, " R9"}, "freeValid", 32'(rbFreeV), 32'(efv));
    check({req, " R9"}, "freeIdx", 32'(rbFree), 32'(efi));
    check({req, " R9"}, "freeIdx wf", 32'(wfFree), 32'(efi));
    for (int s = 0; s < SETS; s++) begin
      for (int p = 0; p < P; p++) lkSet[p*SET_W +: SET_W] = 3'((s + p) % SETS);
      #0.1;
      for (int p = 0; p < P; p++) begin
        int q;
        q = (s + p) % SETS;
        expect_look(1'b0, q, eh, ei, ee);
        check({req, " R6 R8"}, $sformatf("rb hit p%0d set%0d", p, q), 32'(rbHit[p]), 32'(eh));
        check({req, " R7"}, $sformatf("rb idx p%0d set%0d", p, q), 32'(rbIdx[p*IDX_W +: IDX_W]), 32'(ei));
        check({req, " R7"}, $sformatf("rb entry p%0d set%0d", p, q), 32'(rbEntry[p*ENTRY_W +: ENTRY_W]), 32'(ee));
        expect_look(1'b1, q, eh, ei, ee);
        check({req, " R10"}, $sformatf("wf hit p%0d set%0d", p, q), 32'(wfHit[p]), 32'(eh));
        check({req, " R10"}, $sformatf("wf idx p%0d set%0d", p, q), 32'(wfIdx[p*IDX_W +: IDX_W]), 32'(ei));
        check({req, " R10"}, $sformatf("wf entry p%0d set%0d", p, q), 32'(wfEntry[p*ENTRY_W +: ENTRY_W]), 32'(ee));
      end
    end
  endtask

  task automatic do_op(input string req, input bit en, input int op, input int idx,
                       input logic [PAY_W-1:0] pay);
    @(negedge clk);
    wrEn = en; wrOp = 2'(op); wrIdx = IDX_W'(idx); wrPayload = pay;
    for (int i = 0; i < N; i++) mView[i] = mStore[i];
    if (en && op < 2)  mView[idx] = {1'b1, pay};
    if (en && op == 2) mView[idx][16] = 1'b0;
    sweep(req);
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    for (int i = 0; i < N; i++) mStore[i] = mView[i];
    sweep(req);
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin mStore[i] = '0; mView[i] = '0; end
  endtask

  initial begin
    model_reset();
    #1;
    sweep("R1 reset");
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    sweep("R1 after release");

    do_op("R2 alloc e0", 1, 0, 0, mk(10, 3, 1, 1, 2, 0, 5));
    do_op("R2 alloc e1 same set, R6 other tag, R7 lowest", 1, 0, 1, mk(3, 3, 2, 0, 1, 1, 2));
    do_op("R2 alloc e2", 1, 0, 2, mk(15, 5, 3, 1, 3, 0, 7));
    do_op("R3 update e0", 1, 1, 0, mk(1, 6, 0, 0, 1, 0, 4));
    do_op("R5 op3", 1, 3, 1, mk(0, 0, 0, 0, 0, 0, 0));
    do_op("R5 wrEn low", 0, 0, 2, mk(7, 1, 1, 1, 1, 1, 1));
    do_op("R9 fill last", 1, 0, 3, mk(9, 0, 1, 0, 2, 1, 3));
    do_op("R4 retire e1", 1, 2, 1, mk(0, 0, 0, 0, 0, 0, 0));
    do_op("R4 retire e0 fields kept", 1, 2, 0, mk(12, 2, 2, 1, 1, 1, 6));
    do_op("R3 update revives e0", 1, 1, 0, mk(2, 5, 1, 1, 0, 0, 1));

    for (int k = 0; k < 40; k++)
      do_op("R8 mixed", 1, (k * 7 + 3) % 4, (k * 5 + 1) % N,
            PAY_W'((k * 40503 + 12345) & 16'hFFFF));

    @(negedge clk);
    rst = 1'b1;
    #0.2;
    model_reset();
    sweep("R1 mid-run reset");
    @(negedge clk);
    rst = 1'b0;
    do_op("R2 alloc after reset", 1, 0, 2, mk(4, 4, 0, 1, 2, 1, 0));

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule